// File: doc/BRIEF.md
# Priority-Driven Scratchpad Block Allocator

This block keeps the placement of virtual scratchpad blocks across a small pool of equal-size on-chip blocks and a pool of protected off-chip eviction slots. Each block is 1 KB by default. Software names a block by a virtual block number. It sends allocate, clear and delete commands on a valid/ready command stream. Every command carries a process ID and a priority, plus a flag that says whether the priority belongs to the whole virtual scratchpad or only to the block.

When the on-chip pool is full, a new allocation can take the slot of the lowest-priority resident block. The allocator moves the displaced block off-chip with a DMA copy. Only this allocator ever starts an eviction. If nothing outranks the new block, the new block is mapped off-chip.

Deleting a process releases its blocks. Blocks of high priority are zero-filled first. Blocks that were evicted earlier are then reloaded into the freed on-chip space. A poll port reads back the status, the on-chip flag and the physical index of any virtual block, so that an operation in progress can be watched until it completes.

Top module: `spad_blk_alloc`

## Requirements
- R1: An allocate command for a virtual block that is not in use, when an on-chip block is free, takes the lowest-numbered free on-chip block. The status becomes ready (2) in the cycle after the command is accepted, and no DMA command is issued.
- R2: When no on-chip block is free, the victim is the resident block with the lowest effective priority that is not pinned and is strictly lower than the new block. Among equal priorities the lowest on-chip index wins. The victim is copied with one DMA command from its on-chip block to the lowest free off-chip slot, and the new block then takes the victim's on-chip block.
- R3: The effective priority is {scratchpad flag, priority}. A block carrying a scratchpad-level priority therefore outranks every block-level priority, and a block-level request can never evict it.
- R4: When there is no victim, the new block takes the lowest free off-chip slot without any DMA. When no slot is free either, its status becomes failed (4) and no other entry changes.
- R5: While a DMA command is pending for an operation, the affected entries read busy (1). Placement and ready status change only after dma_done.
- R6: The DMA request port is valid/ready. A request is held with stable fields until dma_ready is high, and only one command is outstanding at a time. On-chip block i is at address i*1024. Off-chip slot s is at address 0x8000+s*1024. Copy and zero commands are 1024 bytes long.
- R7: Delete (op 1) releases every entry with the given process ID in ascending virtual block order. An on-chip entry whose effective priority is at least 8 is zero-filled at its on-chip address (dma_zero=1) before it is released. All other entries are released with no DMA.
- R8: After a delete, while both a free on-chip block and an evicted off-chip entry exist, the evicted entry with the highest effective priority is reloaded into the lowest free on-chip block. Ties go to the lowest virtual block number.
- R9: Clear (op 2) of a ready entry zero-fills its current location and leaves its placement unchanged.
- R10: An allocate for a virtual block already in use, or a clear of an entry that is not ready, has no effect: no DMA is issued and the entry does not change.
- R11: cmd_ready is high only while the allocator is idle. A command held on the stream while cmd_ready is low is taken when cmd_ready returns high.
- R12: After reset every entry reads free (0), cmd_ready is high and dma_valid is low. Allocate is op 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | 0 allocate, 1 delete, 2 clear |
| cmd_vblk | input | 4 | Virtual block number |
| cmd_pid | input | 4 | Process ID |
| cmd_prio | input | 3 | Priority value |
| cmd_app | input | 1 | Priority applies to the whole virtual scratchpad |
| cmd_pin | input | 1 | Block is pinned and never evicted |
| poll_vblk | input | 4 | Virtual block to read back |
| poll_status | output | 3 | 0 free, 1 busy, 2 ready, 4 failed |
| poll_onchip | output | 1 | Entry is placed on-chip |
| poll_index | output | 3 | On-chip block or off-chip slot index |
| dma_valid | output | 1 | DMA request valid |
| dma_ready | input | 1 | DMA request accepted |
| dma_zero | output | 1 | Zero-fill destination instead of copying |
| dma_src | output | 16 | Source byte address |
| dma_dst | output | 16 | Destination byte address |
| dma_len | output | 11 | Transfer length in bytes |
| dma_done | input | 1 | Single-cycle completion pulse |

## Verification
The bench sets up a tie between two equal lowest-priority resident blocks while a pinned block of even lower priority is present. A selector that ignores the pin, or that breaks ties toward the higher index, emits the wrong copy source. It then fills the pool with scratchpad-level blocks and sends a block-level request at the highest priority. A design that compares only the raw priority evicts a scratchpad block when it should go off-chip. The delete sequences check zero-fill against the threshold and check reload order, including a tie between two evicted entries. A wrong order shows up as mismatched copy addresses in the scoreboard. The DMA port holds back-pressure for several cycles, which exposes requests that change before acceptance and status that turns ready before dma_done.

// File: rtl/spad_alloc_pkg.sv
package spad_alloc_pkg;

  localparam logic [1:0] OP_ALLOC  = 2'd0;
  localparam logic [1:0] OP_DELETE = 2'd1;
  localparam logic [1:0] OP_CLEAR  = 2'd2;

  localparam logic [2:0] ST_FREE  = 3'd0;
  localparam logic [2:0] ST_BUSY  = 3'd1;
  localparam logic [2:0] ST_READY = 3'd2;
  localparam logic [2:0] ST_FAIL  = 3'd4;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_WAIT, S_DEL, S_RST
  } fsm_e;

  typedef enum logic [1:0] {
    PH_EVICT, PH_CLEAR, PH_DELZ, PH_RESTORE
  } phase_e;

endpackage

// File: rtl/spad_first_free.sv
module spad_first_free #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] used,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!used[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/spad_victim_sel.sv
module spad_victim_sel #(
  parameter int N  = 4,
  parameter int W  = 2,
  parameter int EW = 4
) (
  input  logic [N-1:0]         cand,
  input  logic [N-1:0][EW-1:0] prio,
  input  logic [EW-1:0]        new_prio,
  output logic                 found,
  output logic [W-1:0]         idx
);
  logic          any_c;
  logic [EW-1:0] best_c;

  always_comb begin
    any_c  = 1'b0;
    best_c = '0;
    idx    = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!any_c || prio[i] < best_c)) begin
        any_c  = 1'b1;
        best_c = prio[i];
        idx    = W'(i);
      end
    end
    found = any_c && (best_c < new_prio);
  end
endmodule

// File: rtl/spad_restore_sel.sv
module spad_restore_sel #(
  parameter int N  = 8,
  parameter int W  = 3,
  parameter int EW = 4
) (
  input  logic [N-1:0]         cand,
  input  logic [N-1:0][EW-1:0] prio,
  output logic                 found,
  output logic [W-1:0]         idx
);
  logic [EW-1:0] best_c;

  always_comb begin
    found  = 1'b0;
    best_c = '0;
    idx    = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || prio[i] > best_c)) begin
        found  = 1'b1;
        best_c = prio[i];
        idx    = W'(i);
      end
    end
  end
endmodule

// File: rtl/spad_blk_alloc.sv
module spad_blk_alloc
  import spad_alloc_pkg::*;
#(
  parameter int          NUM_BLK     = 4,
  parameter int          NUM_SLOT    = 6,
  parameter int          NUM_VBLK    = 12,
  parameter int          PID_W       = 4,
  parameter int          PRIO_W      = 3,
  parameter int          BLK_BYTES   = 1024,
  parameter int          ADDR_W      = 16,
  parameter int          ZERO_PRIO   = 8,
  parameter logic [15:0] ONCHIP_BASE = 16'h0000,
  parameter logic [15:0] OFFCHIP_BASE = 16'h8000,
  localparam int EW    = PRIO_W + 1,
  localparam int BW    = $clog2(NUM_BLK),
  localparam int SW    = $clog2(NUM_SLOT),
  localparam int VB_W  = $clog2(NUM_VBLK),
  localparam int IDX_W = (BW > SW) ? BW : SW,
  localparam int LEN_W = $clog2(BLK_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [VB_W-1:0]   cmd_vblk,
  input  logic [PID_W-1:0]  cmd_pid,
  input  logic [PRIO_W-1:0] cmd_prio,
  input  logic              cmd_app,
  input  logic              cmd_pin,
  input  logic [VB_W-1:0]   poll_vblk,
  output logic [2:0]        poll_status,
  output logic              poll_onchip,
  output logic [IDX_W-1:0]  poll_index,
  output logic              dma_valid,
  input  logic              dma_ready,
  output logic              dma_zero,
  output logic [ADDR_W-1:0] dma_src,
  output logic [ADDR_W-1:0] dma_dst,
  output logic [LEN_W-1:0]  dma_len,
  input  logic              dma_done
);

  // placement table, one entry per virtual block
  logic              tbl_valid  [NUM_VBLK];
  logic [PID_W-1:0]  tbl_pid    [NUM_VBLK];
  logic [EW-1:0]     tbl_eff    [NUM_VBLK];
  logic              tbl_pin    [NUM_VBLK];
  logic              tbl_onchip [NUM_VBLK];
  logic              tbl_evict  [NUM_VBLK];
  logic [IDX_W-1:0]  tbl_idx    [NUM_VBLK];
  logic [2:0]        tbl_stat   [NUM_VBLK];

  // physical pools
  logic [NUM_BLK-1:0]  blk_used;
  logic [VB_W-1:0]     blk_owner [NUM_BLK];
  logic [NUM_SLOT-1:0] slot_used;

  fsm_e              state;
  phase_e            phase;
  logic [VB_W-1:0]   cur_v, vic_v;
  logic [BW-1:0]     vic_blk;
  logic [SW-1:0]     slot_q;
  logic [PID_W-1:0]  cur_pid;
  logic              dz_q;
  logic [ADDR_W-1:0] src_q, dst_q;

  logic [EW-1:0] cmd_eff;
  logic          accept;
  assign cmd_eff   = {cmd_app, cmd_prio};
  assign cmd_ready = (state == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  function automatic logic [ADDR_W-1:0] on_addr(input logic [BW-1:0] b);
    return ADDR_W'(ONCHIP_BASE) + ADDR_W'(b) * ADDR_W'(BLK_BYTES);
  endfunction

  function automatic logic [ADDR_W-1:0] off_addr(input logic [SW-1:0] s);
    return ADDR_W'(OFFCHIP_BASE) + ADDR_W'(s) * ADDR_W'(BLK_BYTES);
  endfunction

  // per-block view of the resident entry
  logic [NUM_BLK-1:0]         blk_cand;
  logic [NUM_BLK-1:0][EW-1:0] blk_prio;
  logic [NUM_VBLK-1:0]        rst_cand;
  logic [NUM_VBLK-1:0][EW-1:0] eff_pk;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    assign blk_prio[b] = tbl_eff[blk_owner[b]];
    assign blk_cand[b] = blk_used[b] && !tbl_pin[blk_owner[b]];
  end

  for (genvar v = 0; v < NUM_VBLK; v++) begin : g_ent
    assign eff_pk[v]   = tbl_eff[v];
    assign rst_cand[v] = tbl_valid[v] && tbl_evict[v] && !tbl_onchip[v];
  end

  logic            fb_found, fs_found, vs_found, rs_found;
  logic [BW-1:0]   fb_idx, vs_idx;
  logic [SW-1:0]   fs_idx;
  logic [VB_W-1:0] rs_idx;

  spad_first_free #(.N(NUM_BLK), .W(BW)) u_free_blk (
    .used(blk_used), .found(fb_found), .idx(fb_idx)
  );

  spad_first_free #(.N(NUM_SLOT), .W(SW)) u_free_slot (
    .used(slot_used), .found(fs_found), .idx(fs_idx)
  );

  spad_victim_sel #(.N(NUM_BLK), .W(BW), .EW(EW)) u_victim (
    .cand(blk_cand), .prio(blk_prio), .new_prio(cmd_eff),
    .found(vs_found), .idx(vs_idx)
  );

  spad_restore_sel #(.N(NUM_VBLK), .W(VB_W), .EW(EW)) u_restore (
    .cand(rst_cand), .prio(eff_pk), .found(rs_found), .idx(rs_idx)
  );

  // first entry owned by the process being deleted
  logic            dh_found;
  logic [VB_W-1:0] dh_idx;
  always_comb begin
    dh_found = 1'b0;
    dh_idx   = '0;
    for (int i = NUM_VBLK - 1; i >= 0; i--) begin
      if (tbl_valid[i] && tbl_pid[i] == cur_pid) begin
        dh_found = 1'b1;
        dh_idx   = VB_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VBLK; i++) begin
        tbl_valid[i]  <= 1'b0;
        tbl_pid[i]    <= '0;
        tbl_eff[i]    <= '0;
        tbl_pin[i]    <= 1'b0;
        tbl_onchip[i] <= 1'b0;
        tbl_evict[i]  <= 1'b0;
        tbl_idx[i]    <= '0;
        tbl_stat[i]   <= ST_FREE;
      end
      for (int i = 0; i < NUM_BLK; i++) blk_owner[i] <= '0;
      blk_used  <= '0;
      slot_used <= '0;
      state     <= S_IDLE;
      phase     <= PH_EVICT;
      cur_v     <= '0;
      vic_v     <= '0;
      vic_blk   <= '0;
      slot_q    <= '0;
      cur_pid   <= '0;
      dz_q      <= 1'b0;
      src_q     <= '0;
      dst_q     <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          case (cmd_op)
            OP_ALLOC: if (!tbl_valid[cmd_vblk]) begin
              tbl_pid[cmd_vblk]   <= cmd_pid;
              tbl_eff[cmd_vblk]   <= cmd_eff;
              tbl_pin[cmd_vblk]   <= cmd_pin;
              tbl_evict[cmd_vblk] <= 1'b0;
              if (fb_found) begin
                tbl_valid[cmd_vblk]  <= 1'b1;
                tbl_onchip[cmd_vblk] <= 1'b1;
                tbl_idx[cmd_vblk]    <= IDX_W'(fb_idx);
                tbl_stat[cmd_vblk]   <= ST_READY;
                blk_used[fb_idx]     <= 1'b1;
                blk_owner[fb_idx]    <= cmd_vblk;
              end else if (vs_found && fs_found) begin
                tbl_valid[cmd_vblk]         <= 1'b1;
                tbl_onchip[cmd_vblk]        <= 1'b0;
                tbl_stat[cmd_vblk]          <= ST_BUSY;
                tbl_stat[blk_owner[vs_idx]] <= ST_BUSY;
                cur_v   <= cmd_vblk;
                vic_v   <= blk_owner[vs_idx];
                vic_blk <= vs_idx;
                slot_q  <= fs_idx;
                dz_q    <= 1'b0;
                src_q   <= on_addr(vs_idx);
                dst_q   <= off_addr(fs_idx);
                phase   <= PH_EVICT;
                state   <= S_REQ;
              end else if (fs_found) begin
                tbl_valid[cmd_vblk]  <= 1'b1;
                tbl_onchip[cmd_vblk] <= 1'b0;
                tbl_idx[cmd_vblk]    <= IDX_W'(fs_idx);
                tbl_stat[cmd_vblk]   <= ST_READY;
                slot_used[fs_idx]    <= 1'b1;
              end else begin
                tbl_valid[cmd_vblk] <= 1'b0;
                tbl_stat[cmd_vblk]  <= ST_FAIL;
              end
            end
            OP_CLEAR: if (tbl_valid[cmd_vblk] && tbl_stat[cmd_vblk] == ST_READY) begin
              tbl_stat[cmd_vblk] <= ST_BUSY;
              cur_v <= cmd_vblk;
              dz_q  <= 1'b1;
              src_q <= '0;
              dst_q <= tbl_onchip[cmd_vblk] ? on_addr(tbl_idx[cmd_vblk][BW-1:0])
                                            : off_addr(tbl_idx[cmd_vblk][SW-1:0]);
              phase <= PH_CLEAR;
              state <= S_REQ;
            end
            OP_DELETE: begin
              cur_pid <= cmd_pid;
              state   <= S_DEL;
            end
            default: ;
          endcase
        end
        S_REQ: if (dma_ready) state <= S_WAIT;
        S_WAIT: if (dma_done) begin
          case (phase)
            PH_EVICT: begin
              tbl_onchip[vic_v] <= 1'b0;
              tbl_idx[vic_v]    <= IDX_W'(slot_q);
              tbl_evict[vic_v]  <= 1'b1;
              tbl_stat[vic_v]   <= ST_READY;
              slot_used[slot_q] <= 1'b1;
              tbl_onchip[cur_v] <= 1'b1;
              tbl_idx[cur_v]    <= IDX_W'(vic_blk);
              tbl_stat[cur_v]   <= ST_READY;
              blk_owner[vic_blk] <= cur_v;
              state <= S_IDLE;
            end
            PH_CLEAR: begin
              tbl_stat[cur_v] <= ST_READY;
              state <= S_IDLE;
            end
            PH_DELZ: begin
              tbl_valid[cur_v]  <= 1'b0;
              tbl_onchip[cur_v] <= 1'b0;
              tbl_evict[cur_v]  <= 1'b0;
              tbl_stat[cur_v]   <= ST_FREE;
              blk_used[tbl_idx[cur_v][BW-1:0]] <= 1'b0;
              state <= S_DEL;
            end
            default: begin
              tbl_onchip[cur_v] <= 1'b1;
              tbl_idx[cur_v]    <= IDX_W'(vic_blk);
              tbl_evict[cur_v]  <= 1'b0;
              tbl_stat[cur_v]   <= ST_READY;
              slot_used[slot_q] <= 1'b0;
              blk_used[vic_blk] <= 1'b1;
              blk_owner[vic_blk] <= cur_v;
              state <= S_RST;
            end
          endcase
        end
        S_DEL: begin
          if (!dh_found) begin
            state <= S_RST;
          end else if (tbl_onchip[dh_idx] && tbl_eff[dh_idx] >= EW'(ZERO_PRIO)) begin
            tbl_stat[dh_idx] <= ST_BUSY;
            cur_v <= dh_idx;
            dz_q  <= 1'b1;
            src_q <= '0;
            dst_q <= on_addr(tbl_idx[dh_idx][BW-1:0]);
            phase <= PH_DELZ;
            state <= S_REQ;
          end else begin
            if (tbl_onchip[dh_idx]) blk_used[tbl_idx[dh_idx][BW-1:0]] <= 1'b0;
            else                    slot_used[tbl_idx[dh_idx][SW-1:0]] <= 1'b0;
            tbl_valid[dh_idx]  <= 1'b0;
            tbl_onchip[dh_idx] <= 1'b0;
            tbl_evict[dh_idx]  <= 1'b0;
            tbl_stat[dh_idx]   <= ST_FREE;
          end
        end
        S_RST: begin
          if (fb_found && rs_found) begin
            tbl_stat[rs_idx] <= ST_BUSY;
            cur_v   <= rs_idx;
            vic_blk <= fb_idx;
            slot_q  <= tbl_idx[rs_idx][SW-1:0];
            dz_q    <= 1'b0;
            src_q   <= off_addr(tbl_idx[rs_idx][SW-1:0]);
            dst_q   <= on_addr(fb_idx);
            phase   <= PH_RESTORE;
            state   <= S_REQ;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign dma_valid   = (state == S_REQ);
  assign dma_zero    = dz_q;
  assign dma_src     = src_q;
  assign dma_dst     = dst_q;
  assign dma_len     = LEN_W'(BLK_BYTES);
  assign poll_status = tbl_stat[poll_vblk];
  assign poll_onchip = tbl_onchip[poll_vblk];
  assign poll_index  = tbl_idx[poll_vblk];

  // R6: request fields hold while back-pressured
  p_dma_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid && !dma_ready |=> dma_valid && $stable(dma_src) && $stable(dma_dst) && $stable(dma_zero));

  // R11: no command taken while a DMA request is open
  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid |-> !cmd_ready);

  // R2: an evicted block is unpinned and strictly lower than the newcomer
  p_victim_lower_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_valid && phase == PH_EVICT) |-> (tbl_eff[vic_v] < tbl_eff[cur_v]) && !tbl_pin[vic_v]);

  // R5: the entry stays busy until the done pulse
  p_busy_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> tbl_stat[cur_v] == ST_BUSY);

  // R2: every used on-chip block points back at an on-chip entry holding it
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_chk
    p_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && blk_used[b]) |->
        tbl_valid[blk_owner[b]] && tbl_onchip[blk_owner[b]] &&
        tbl_idx[blk_owner[b]][BW-1:0] == BW'(b));
  end

endmodule

// File: tb/test_spad_blk_alloc.sv
module test_spad_blk_alloc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [3:0]  cmd_vblk = '0;
  logic [3:0]  cmd_pid = '0;
  logic [2:0]  cmd_prio = '0;
  logic        cmd_app = 1'b0;
  logic        cmd_pin = 1'b0;
  logic [3:0]  poll_vblk = '0;
  logic [2:0]  poll_status;
  logic        poll_onchip;
  logic [2:0]  poll_index;
  logic        dma_valid;
  logic        dma_ready = 1'b0;
  logic        dma_zero;
  logic [15:0] dma_src, dma_dst;
  logic [10:0] dma_len;
  logic        dma_done = 1'b0;

  int checks = 0;
  int fails = 0;
  int dma_seen = 0;
  logic [32:0] exp_q[$];

  always #2 clk = ~clk;

  spad_blk_alloc i_spad_blk_alloc (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_vblk(cmd_vblk), .cmd_pid(cmd_pid), .cmd_prio(cmd_prio),
    .cmd_app(cmd_app), .cmd_pin(cmd_pin),
    .poll_vblk(poll_vblk), .poll_status(poll_status),
    .poll_onchip(poll_onchip), .poll_index(poll_index),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_zero(dma_zero),
    .dma_src(dma_src), .dma_dst(dma_dst), .dma_len(dma_len),
    .dma_done(dma_done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] on_a(input int b);  return 16'(b * 1024); endfunction
  function automatic logic [15:0] off_a(input int s); return 16'(32'h8000 + s * 1024); endfunction

  task automatic exp_copy(input logic [15:0] s, input logic [15:0] d);
    exp_q.push_back({1'b0, s, d});
  endtask
  task automatic exp_zero(input logic [15:0] d);
    exp_q.push_back({1'b1, 16'h0000, d});
  endtask

  // DMA model and scoreboard monitor, with back-pressure
  initial begin
    forever begin
      @(negedge clk);
      if (dma_valid) begin
        logic [32:0] first;
        logic [32:0] got;
        first = {dma_zero, dma_src, dma_dst};
        repeat (2) @(negedge clk);
        got = {dma_zero, dma_src, dma_dst};
        chk(dma_valid && got == first, "R6 request held under back-pressure", got, first);
        chk(dma_len == 11'd1024, "R6 length", dma_len, 1024);
        dma_ready = 1'b1;
        dma_seen++;
        if (exp_q.size() == 0) chk(1'b0, "R10 unexpected DMA command", got, 0);
        else begin
          logic [32:0] e;
          e = exp_q.pop_front();
          chk(got == e, "R6 DMA command matches scoreboard", got, e);
        end
        @(negedge clk);
        dma_ready = 1'b0;
        repeat (2) @(negedge clk);
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
      end
    end
  end

  task automatic do_cmd(input logic [1:0] op, input int v, input int pid, input int prio,
                        input bit app, input bit pin, input bit exp_busy);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_vblk = 4'(v); cmd_pid = 4'(pid); cmd_prio = 3'(prio);
    cmd_app = app; cmd_pin = pin; cmd_valid = 1'b1; poll_vblk = 4'(v);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (exp_busy) chk(poll_status == 3'd1, "R5 busy while DMA pending", poll_status, 1);
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic chk_ent(input int v, input int st, input bit on, input int idx, input string tag);
    poll_vblk = 4'(v);
    #1;
    chk(poll_status == 3'(st), {tag, " status"}, poll_status, st);
    if (st == 2) begin
      chk(poll_onchip == on, {tag, " onchip"}, poll_onchip, on);
      chk(poll_index == 3'(idx), {tag, " index"}, poll_index, idx);
    end
  endtask

  task automatic chk_dma(input int n, input string tag);
    chk(dma_seen == n && exp_q.size() == 0, tag, dma_seen, n);
  endtask

  task automatic finish_tb;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_tb();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    for (int v = 0; v < 12; v++) begin
      poll_vblk = 4'(v); #1;
      chk(poll_status == 3'd0, "R12 entry free after reset", poll_status, 0);
    end
    chk(cmd_ready == 1'b1 && dma_valid == 1'b0, "R12 idle after reset", {cmd_ready, dma_valid}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R11 ready when idle", cmd_ready, 1);

    // R1 fill on-chip pool (v0 pinned, low priority)
    do_cmd(2'd0, 0, 1, 1, 0, 1, 0); chk_ent(0, 2, 1, 0, "R1 v0");
    do_cmd(2'd0, 1, 1, 5, 0, 0, 0); chk_ent(1, 2, 1, 1, "R1 v1");
    do_cmd(2'd0, 2, 2, 2, 0, 0, 0); chk_ent(2, 2, 1, 2, "R1 v2");
    do_cmd(2'd0, 3, 2, 2, 0, 0, 0); chk_ent(3, 2, 1, 3, "R1 v3");
    chk_dma(0, "R1 no DMA on direct placement");

    // R2 tie at prio 2, pinned prio 1 skipped -> block 2 evicted to slot 0
    exp_copy(on_a(2), off_a(0));
    do_cmd(2'd0, 4, 3, 3, 0, 0, 1);
    chk_ent(4, 2, 1, 2, "R2 new block takes victim block");
    chk_ent(2, 2, 0, 0, "R2 victim moved to slot 0");
    chk_ent(0, 2, 1, 0, "R2 pinned block untouched");
    chk_dma(1, "R2 one eviction copy");

    // R4 nothing lower -> slot 1, no DMA
    do_cmd(2'd0, 5, 3, 0, 0, 0, 0);
    chk_ent(5, 2, 0, 1, "R4 off-chip placement");
    chk_dma(1, "R4 no DMA");

    // R3 scratchpad-level blocks
    exp_copy(on_a(3), off_a(2));
    do_cmd(2'd0, 6, 4, 0, 1, 0, 1);
    chk_ent(6, 2, 1, 3, "R3 scratchpad prio 0 evicts block prio 2");
    exp_copy(on_a(2), off_a(3));
    do_cmd(2'd0, 7, 5, 1, 1, 0, 1);
    chk_ent(7, 2, 1, 2, "R3 v7 placed");
    chk_ent(4, 2, 0, 3, "R2 v4 evicted to slot 3");
    exp_copy(on_a(1), off_a(4));
    do_cmd(2'd0, 8, 6, 7, 0, 0, 1);
    chk_ent(8, 2, 1, 1, "R2 v8 placed");
    do_cmd(2'd0, 9, 6, 7, 0, 0, 0);
    chk_ent(9, 2, 0, 5, "R3 block prio 7 cannot evict scratchpad blocks");
    chk_ent(6, 2, 1, 3, "R3 scratchpad block stays");
    chk_dma(4, "R3 DMA count");

    // R4 pool exhausted
    do_cmd(2'd0, 10, 7, 0, 0, 0, 0);
    chk_ent(10, 4, 0, 0, "R4 failed status");
    chk_ent(9, 2, 0, 5, "R4 others unchanged");

    // R10 ignored commands
    do_cmd(2'd0, 9, 7, 7, 1, 0, 0);
    chk_ent(9, 2, 0, 5, "R10 re-allocate ignored");
    do_cmd(2'd2, 10, 7, 0, 0, 0, 0);
    chk_ent(10, 4, 0, 0, "R10 clear of failed entry ignored");
    chk_dma(4, "R10 no DMA");

    // R9 clear in place
    exp_zero(on_a(1));
    do_cmd(2'd2, 8, 6, 0, 0, 0, 1);
    chk_ent(8, 2, 1, 1, "R9 placement kept after clear");
    chk_dma(5, "R9 one zero command");

    // R7 / R8 delete with zero then reload highest (v1 prio 5)
    exp_zero(on_a(3));
    exp_copy(off_a(4), on_a(3));
    do_cmd(2'd1, 0, 4, 0, 0, 0, 0);
    chk_ent(6, 0, 0, 0, "R7 deleted entry free");
    chk_ent(1, 2, 1, 3, "R8 highest evicted reloaded");
    chk_dma(7, "R7 zero then reload");

    exp_zero(on_a(2));
    exp_copy(off_a(3), on_a(2));
    do_cmd(2'd1, 0, 5, 0, 0, 0, 0);
    chk_ent(4, 2, 1, 2, "R8 v4 reloaded");
    chk_dma(9, "R8 DMA count");

    // R7 below threshold: no zero; R8 tie -> lowest vblk to lowest block
    exp_copy(off_a(0), on_a(0));
    exp_copy(off_a(2), on_a(3));
    do_cmd(2'd1, 0, 1, 0, 0, 0, 0);
    chk_ent(0, 0, 0, 0, "R7 v0 released");
    chk_ent(1, 0, 0, 0, "R7 v1 released");
    chk_ent(2, 2, 1, 0, "R8 tie lowest vblk first");
    chk_ent(3, 2, 1, 3, "R8 second reload");
    chk_dma(11, "R7 no zero below threshold");

    // delete off-chip + low on-chip, then reuse freed block
    do_cmd(2'd1, 0, 3, 0, 0, 0, 0);
    chk_ent(5, 0, 0, 0, "R7 off-chip entry released");
    do_cmd(2'd0, 11, 8, 0, 0, 0, 0);
    chk_ent(11, 2, 1, 2, "R1 freed block reused");
    chk_dma(11, "R7 no DMA for low entries");

    repeat (4) @(negedge clk);
    finish_tb();
  end

endmodule